// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a 10-bit successive-approximation converter in a microcontroller-style peripheral. Software writes a control word with an enable bit, a start/busy bit, a 2-bit conversion clock select and an interrupt enable. The block then walks a 10-step binary search. It shows a trial code to an external comparator, keeps or drops each bit, and on completion loads the result register and raises a sticky done flag.

The sequencer follows the core's sleep signal, and its response depends on the clock select. Code 2'b11 selects the internal RC timebase. With that select, the first step is held back one cycle after start so that a sleep request can take effect first. The conversion then runs to its end in sleep. On completion it either sends a one-cycle wake request or, with the interrupt disabled, drops the converter into its off state. With any other select, sleep aborts the conversion and powers the converter down. In both cases the enable bit keeps reading 1.

A companion compare unit can also start a conversion. When its mode field is 4'b1011, each match sends a one-cycle reset pulse back to the timer. The same match sets busy only if the converter is enabled.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, enable, busy, clock select, interrupt enable, done, wake request and timer reset all read 0, and the low-power output reads 1.
- R2: A control write with enable=1 and start=1 sets busy on the write edge. A write with start=1 but enable=0 leaves busy at 0.
- R3: A conversion resolves 10 bits MSB first and yields the largest code C with comparator input (vin >= trial code) true for every kept bit, so result equals vin. Busy clears, done sets and the result loads on the same edge. Counted in edges from the write edge inclusive, busy first reads 0 after 10*D+1 edges, where D is 2, 8 and 32 for select codes 00, 01 and 10.
- R4: With select 2'b11 (RC timebase, D = 4), one extra delay cycle comes before the first step, so busy first reads 0 after 42 edges.
- R5: Done stays set until done-clear is pulsed. If completion and done-clear fall on the same edge, done ends set.
- R6: A control write with start=0 during a conversion clears busy. The result keeps its previous value and done stays 0.
- R7: With select other than 2'b11, raising sleep during a conversion aborts it. Busy clears, done stays 0, low-power reads 1 and enable still reads 1.
- R8: With select 2'b11, a conversion completes in sleep. With the interrupt enabled, wake pulses for exactly one cycle and low-power stays 0. With the interrupt disabled, there is no wake pulse, low-power reads 1 and enable reads 1.
- R9: A compare match while the mode equals 4'b1011 gives a one-cycle timer reset on the next edge, whether enabled or not. It sets busy only when enabled. Any other mode does neither.
- R10: Low-power reads 0 while enabled and not in the off state. The off state clears on the first edge with sleep low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low synchronous reset |
| cfgWe | input | 1 | control word write strobe |
| cfgEnable | input | 1 | written enable bit |
| cfgStart | input | 1 | written start/busy bit |
| cfgClkSel | input | 2 | written conversion clock select |
| cfgIrqEn | input | 1 | written interrupt enable |
| doneClr | input | 1 | clears the done flag |
| sleepReq | input | 1 | core sleep level |
| cmpMode | input | 4 | companion compare unit mode field |
| cmpMatch | input | 1 | compare match pulse |
| cmpIn | input | 1 | comparator output, 1 when input >= trial code |
| enable | output | 1 | enable bit readback |
| busy | output | 1 | start/busy bit readback |
| clkSel | output | 2 | clock select readback |
| irqEn | output | 1 | interrupt enable readback |
| dacCode | output | 10 | trial code to the comparator |
| result | output | 10 | conversion result |
| done | output | 1 | sticky done interrupt flag |
| wakeReq | output | 1 | one-cycle wake request |
| lowPower | output | 1 | converter powered down |
| timerRst | output | 1 | reset pulse to the companion timer |

## Verification
Two pairs of events can land on the same edge. The first pair is the completing last SAR step and a software done-clear. The bench drives done-clear so that it is sampled exactly on the completion edge, which it computes from the divider count, and expects done to end set. The second pair is a compare match and the enable bit: the match comes once with the converter disabled and once enabled. In both cases the timer reset must pulse, and busy is judged against the enable state.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef struct packed {
    logic init;
    logic step;
    logic load;
  } sarCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_CONV} seqState_t;

  localparam logic [3:0] TRIG_MODE = 4'b1011;
  localparam logic [1:0] SEL_RC    = 2'b11;
endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarCmd_t          cmd,
  input  logic             cmpIn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             lastBit
);
  localparam logic [WIDTH-1:0] MSB_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] kept;
  logic [WIDTH-1:0] keptNext;

  assign dacCode  = kept | mask;
  assign lastBit  = mask[0];
  assign keptNext = cmpIn ? (kept | mask) : kept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask <= '0;
      kept <= '0;
    end else if (cmd.init) begin
      mask <= MSB_MASK;
      kept <= '0;
    end else if (cmd.step) begin
      kept <= keptNext;
      mask <= mask >> 1;
    end
  end

  // result is left without reset: its power-on contents are undefined
  always_ff @(posedge clk) begin
    if (cmd.load) result <= keptNext;
  end

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(mask)); // R3
  AST_STEP_SHIFTS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.init) |=> (mask == ($past(mask) >> 1))); // R3
endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int DIV0  = 2,
  parameter int DIV1  = 8,
  parameter int DIV2  = 32,
  parameter int DIVRC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgEnable,
  input  logic       cfgStart,
  input  logic [1:0] cfgClkSel,
  input  logic       cfgIrqEn,
  input  logic       doneClr,
  input  logic       sleepReq,
  input  logic [3:0] cmpMode,
  input  logic       cmpMatch,
  input  logic       lastBit,
  output sarCmd_t    cmd,
  output logic       enable,
  output logic       busy,
  output logic [1:0] clkSel,
  output logic       irqEn,
  output logic       done,
  output logic       wakeReq,
  output logic       lowPower,
  output logic       timerRst
);
  localparam int DIV_A   = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int DIV_B   = (DIV2 > DIVRC) ? DIV2 : DIVRC;
  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CNT_W   = $clog2(DIV_MAX);
  localparam logic [CNT_W-1:0] LIM0  = CNT_W'(DIV0 - 1);
  localparam logic [CNT_W-1:0] LIM1  = CNT_W'(DIV1 - 1);
  localparam logic [CNT_W-1:0] LIM2  = CNT_W'(DIV2 - 1);
  localparam logic [CNT_W-1:0] LIMRC = CNT_W'(DIVRC - 1);

  seqState_t        stateQ;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divLim;
  logic             enQ, irqQ, doneQ, wakeQ, offQ, tmrQ;
  logic [1:0]       selQ;
  logic             enNext, trigHit, startSw, startTrig, go;
  logic             abortSw, abortSleep, abortAny, tick;
  logic [1:0]       selNext;

  always_comb begin
    case (selQ)
      2'b00:   divLim = LIM0;
      2'b01:   divLim = LIM1;
      2'b10:   divLim = LIM2;
      default: divLim = LIMRC;
    endcase
  end

  assign enNext     = cfgWe ? cfgEnable : enQ;
  assign selNext    = cfgWe ? cfgClkSel : selQ;
  assign trigHit    = cmpMatch && (cmpMode == TRIG_MODE);
  assign startSw    = cfgWe && cfgEnable && cfgStart;
  assign startTrig  = trigHit && enNext;
  assign go         = (startSw || startTrig) && !(sleepReq && (selNext != SEL_RC));
  assign abortSw    = cfgWe && !(cfgEnable && cfgStart);
  assign abortSleep = sleepReq && (selQ != SEL_RC);
  assign abortAny   = abortSw || abortSleep;
  assign tick       = (divCnt == divLim);

  assign cmd.init = (stateQ == ST_IDLE) && go;
  assign cmd.step = (stateQ == ST_CONV) && !abortAny && tick;
  assign cmd.load = cmd.step && lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      divCnt <= '0;
      enQ    <= 1'b0;
      selQ   <= 2'b00;
      irqQ   <= 1'b0;
      doneQ  <= 1'b0;
      wakeQ  <= 1'b0;
      offQ   <= 1'b0;
      tmrQ   <= 1'b0;
    end else begin
      wakeQ <= 1'b0;
      tmrQ  <= trigHit;
      if (cfgWe) begin
        enQ  <= cfgEnable;
        selQ <= cfgClkSel;
        irqQ <= cfgIrqEn;
      end
      if (!sleepReq) offQ <= 1'b0;
      if (doneClr) doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (go) begin
            stateQ <= (selNext == SEL_RC) ? ST_DLY : ST_CONV;
            divCnt <= '0;
          end
        end
        default: begin
          if (abortAny) begin
            stateQ <= ST_IDLE;
            if (abortSleep) offQ <= 1'b1;
          end else if (stateQ == ST_DLY) begin
            stateQ <= ST_CONV;
            divCnt <= '0;
          end else if (tick) begin
            divCnt <= '0;
            if (lastBit) begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
              if (sleepReq) begin
                if (irqQ) wakeQ <= 1'b1;
                else      offQ  <= 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign enable   = enQ;
  assign busy     = (stateQ != ST_IDLE);
  assign clkSel   = selQ;
  assign irqEn    = irqQ;
  assign done     = doneQ;
  assign wakeReq  = wakeQ;
  assign lowPower = !enQ || offQ;
  assign timerRst = tmrQ;

  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN) busy |-> enable); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN) (done && !doneClr) |=> done); // R5
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) wakeReq |=> !wakeReq); // R8
  AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rstN) wakeReq |-> $past(sleepReq)); // R8
  AST_TMR_RST_SRC: assert property (@(posedge clk) disable iff (!rstN)
    timerRst |-> $past(cmpMatch && (cmpMode == TRIG_MODE))); // R9
  AST_SLEEP_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sleepReq && (clkSel != SEL_RC)) |=> (!busy && lowPower)); // R7
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int WIDTH = 10,
  parameter int DIV0  = 2,
  parameter int DIV1  = 8,
  parameter int DIV2  = 32,
  parameter int DIVRC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgEnable,
  input  logic             cfgStart,
  input  logic [1:0]       cfgClkSel,
  input  logic             cfgIrqEn,
  input  logic             doneClr,
  input  logic             sleepReq,
  input  logic [3:0]       cmpMode,
  input  logic             cmpMatch,
  input  logic             cmpIn,
  output logic             enable,
  output logic             busy,
  output logic [1:0]       clkSel,
  output logic             irqEn,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             wakeReq,
  output logic             lowPower,
  output logic             timerRst
);
  sarCmd_t cmd;
  logic    lastBit;

  adc_seq_ctl #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIVRC(DIVRC)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable), .cfgStart(cfgStart),
    .cfgClkSel(cfgClkSel), .cfgIrqEn(cfgIrqEn), .doneClr(doneClr), .sleepReq(sleepReq),
    .cmpMode(cmpMode), .cmpMatch(cmpMatch), .lastBit(lastBit), .cmd(cmd),
    .enable(enable), .busy(busy), .clkSel(clkSel), .irqEn(irqEn), .done(done),
    .wakeReq(wakeReq), .lowPower(lowPower), .timerRst(timerRst)
  );

  adc_seq_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmpIn(cmpIn),
    .dacCode(dacCode), .result(result), .lastBit(lastBit)
  );
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0, cfgEnable = 1'b0, cfgStart = 1'b0, cfgIrqEn = 1'b0;
  logic [1:0] cfgClkSel = 2'b00;
  logic       doneClr = 1'b0, sleepReq = 1'b0, cmpMatch = 1'b0;
  logic [3:0] cmpMode = 4'b0000;
  logic       cmpIn;
  logic       enable, busy, irqEn, done, wakeReq, lowPower, timerRst;
  logic [1:0] clkSel;
  logic [9:0] dacCode, result;
  logic [9:0] vin = 10'd0;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  assign cmpIn = (vin >= dacCode);

  adc_seq_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable), .cfgStart(cfgStart),
    .cfgClkSel(cfgClkSel), .cfgIrqEn(cfgIrqEn), .doneClr(doneClr), .sleepReq(sleepReq),
    .cmpMode(cmpMode), .cmpMatch(cmpMatch), .cmpIn(cmpIn), .enable(enable), .busy(busy),
    .clkSel(clkSel), .irqEn(irqEn), .dacCode(dacCode), .result(result), .done(done),
    .wakeReq(wakeReq), .lowPower(lowPower), .timerRst(timerRst)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [9:0] vin;
    logic [9:0] cyc;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{sel: 2'd0, vin: 10'h3FF, cyc: 10'd21},
    '{sel: 2'd0, vin: 10'h000, cyc: 10'd21},
    '{sel: 2'd1, vin: 10'h2AA, cyc: 10'd81},
    '{sel: 2'd2, vin: 10'h155, cyc: 10'd321},
    '{sel: 2'd3, vin: 10'h200, cyc: 10'd42},
    '{sel: 2'd3, vin: 10'h1FF, cyc: 10'd42}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic st, input logic [1:0] sel, input logic irq);
    cfgWe = 1'b1; cfgEnable = en; cfgStart = st; cfgClkSel = sel; cfgIrqEn = irq;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseClr();
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
  endtask

  // returns edges counted from the write edge until busy reads 0, and wake pulses seen
  task automatic waitIdle(output int n, output int wakes);
    n = 1;
    wakes = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
      if (wakeReq) wakes++;
    end
  endtask

  initial begin
    int n, w;
    logic [9:0] prevRes;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 enable", enable, 0);
    chk("R1 busy", busy, 0);
    chk("R1 clkSel", clkSel, 0);
    chk("R1 irqEn", irqEn, 0);
    chk("R1 done", done, 0);
    chk("R1 wakeReq", wakeReq, 0);
    chk("R1 timerRst", timerRst, 0);
    chk("R1 lowPower", lowPower, 1);

    // R2 start while disabled is ignored
    wr(1'b0, 1'b1, 2'b00, 1'b0);
    chk("R2 busy disabled start", busy, 0);

    // R3/R4 vector table
    for (int i = 0; i < NVEC; i++) begin
      vin = VECS[i].vin;
      wr(1'b1, 1'b1, VECS[i].sel, 1'b0);
      chk("R2 busy after start", busy, 1);
      chk("R10 lowPower enabled", lowPower, 0);
      waitIdle(n, w);
      chk((VECS[i].sel == 2'b11) ? "R4 cycles rc" : "R3 cycles", n, int'(VECS[i].cyc));
      chk("R3 result", result, int'(VECS[i].vin));
      chk("R3 done", done, 1);
      repeat (3) @(negedge clk);
      chk("R5 done sticky", done, 1);
      pulseClr();
      chk("R5 done cleared", done, 0);
    end

    // R5 completion and done-clear on the same edge
    vin = 10'h0F0;
    wr(1'b1, 1'b1, 2'b00, 1'b0);
    repeat (19) @(negedge clk);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk("R5 busy at collision", busy, 0);
    chk("R5 set wins over clear", done, 1);
    chk("R3 result collision", result, 10'h0F0);
    pulseClr();

    // R6 software abort
    prevRes = result;
    vin = 10'h333;
    wr(1'b1, 1'b1, 2'b01, 1'b0);
    repeat (10) @(negedge clk);
    wr(1'b1, 1'b0, 2'b01, 1'b0);
    chk("R6 busy after abort", busy, 0);
    repeat (100) @(negedge clk);
    chk("R6 done stays 0", done, 0);
    chk("R6 result kept", result, prevRes);

    // R7 sleep aborts with non-RC select
    wr(1'b1, 1'b1, 2'b00, 1'b1);
    repeat (5) @(negedge clk);
    sleepReq = 1'b1;
    @(negedge clk);
    chk("R7 busy", busy, 0);
    chk("R7 lowPower", lowPower, 1);
    chk("R7 enable kept", enable, 1);
    repeat (40) @(negedge clk);
    chk("R7 done", done, 0);
    chk("R7 result kept", result, prevRes);
    sleepReq = 1'b0;
    @(negedge clk);
    chk("R10 off cleared", lowPower, 0);

    // R8 RC conversion finishing in sleep, interrupt enabled
    vin = 10'h2C3;
    wr(1'b1, 1'b1, 2'b11, 1'b1);
    sleepReq = 1'b1;
    waitIdle(n, w);
    chk("R8 cycles in sleep", n, 42);
    chk("R8 result", result, 10'h2C3);
    chk("R8 one wake pulse", w, 1);
    chk("R8 lowPower with irq", lowPower, 0);
    @(negedge clk);
    chk("R8 wake dropped", wakeReq, 0);
    sleepReq = 1'b0;
    pulseClr();

    // R8 interrupt disabled
    vin = 10'h011;
    wr(1'b1, 1'b1, 2'b11, 1'b0);
    sleepReq = 1'b1;
    waitIdle(n, w);
    chk("R8 result no irq", result, 10'h011);
    chk("R8 no wake", w, 0);
    chk("R8 lowPower no irq", lowPower, 1);
    chk("R8 enable kept", enable, 1);
    sleepReq = 1'b0;
    @(negedge clk);
    chk("R10 off cleared rc", lowPower, 0);
    pulseClr();

    // R9 trigger while disabled
    wr(1'b0, 1'b0, 2'b00, 1'b0);
    cmpMode = 4'b1011;
    cmpMatch = 1'b1;
    @(negedge clk);
    cmpMatch = 1'b0;
    chk("R9 timerRst disabled", timerRst, 1);
    chk("R9 busy disabled", busy, 0);
    @(negedge clk);
    chk("R9 timerRst one cycle", timerRst, 0);

    // R9 trigger while enabled
    vin = 10'h1A5;
    wr(1'b1, 1'b0, 2'b00, 1'b0);
    cmpMatch = 1'b1;
    @(negedge clk);
    cmpMatch = 1'b0;
    chk("R9 timerRst enabled", timerRst, 1);
    chk("R9 busy enabled", busy, 1);
    waitIdle(n, w);
    chk("R9 trigger cycles", n, 21);
    chk("R9 trigger result", result, 10'h1A5);
    pulseClr();

    // R9 other mode: no effect
    cmpMode = 4'b1010;
    cmpMatch = 1'b1;
    @(negedge clk);
    cmpMatch = 1'b0;
    chk("R9 other mode timerRst", timerRst, 0);
    chk("R9 other mode busy", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule